// File: doc/BRIEF.md
# Dual Sync Mark Detector

This block sits on the byte-wide decoded read stream of a disk read channel. While a read is in progress it searches for a two-byte synchronization pattern. The pattern is a first mark of 1Fh followed by a second mark of 69h. Either mark alone is enough to synchronize, so a single corrupted mark does not cost the sector. When only the first mark is seen, the detector projects forward to the slot where the second mark belongs and declares lock there. A direct hit on the second mark and a projected hit therefore give the same timing. In both cases the marker byte presented downstream is 69h.

Until lock, every output byte is forced to zero, so the first non-zero byte a consumer sees is the 69h marker. After lock, the search stops and bytes pass through unchanged with a one-clock delay. This continues until the read gate drops, which returns the block to its search state.

Top module: `dual_sync_det`

## Requirements
- R1: In reset, and in the clock after any cycle with `rd_gate_i` low, `byte_o` = 00h and `byte_vld_o`, `sync_det_o` and `sync_found_o` are all 0.
- R2: With the gate high and before lock, each valid input byte that causes no detection yields `byte_vld_o` = 1 and `byte_o` = 00h one clock later.
- R3: A valid input byte equal to 69h while searching causes, one clock later, `sync_det_o` = 1, `sync_found_o` = 1 and `byte_o` = 69h.
- R4: A valid 1Fh while searching arms the detector. The valid byte MARK_GAP slots later (default 1, the next valid byte) causes the same outputs as R3 one clock later, whatever its value. A further 1Fh while armed does not restart the wait.
- R5: Cycles with `byte_vld_i` low do not count as byte slots. One clock later `byte_vld_o` = 0 and `sync_det_o` = 0, and `byte_o` holds its value.
- R6: After lock, each valid input byte appears on `byte_o` one clock later with `byte_vld_o` = 1. Later 1Fh or 69h bytes do not raise `sync_det_o` again.
- R7: Dropping `rd_gate_i` clears lock and any armed wait. After the gate returns, a new search starts from the beginning, so a 1Fh seen before the drop has no effect.
- R8: `sync_det_o` is a single-clock pulse and occurs at most once per gate period. `sync_found_o` stays high from the pulse until the gate drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_gate_i | input | 1 | Read gate; low clears all state |
| byte_vld_i | input | 1 | Input byte strobe |
| byte_i | input | DW | Decoded read byte |
| byte_vld_o | output | 1 | Output byte strobe |
| byte_o | output | DW | Zeroed before lock, realigned data after |
| sync_det_o | output | 1 | One-clock lock strobe |
| sync_found_o | output | 1 | Lock level until gate drops |

## Verification
Every result is due exactly one clock after the valid input slot that causes it. This holds for the zeroed preamble byte, the 69h marker with its strobe, passed-through data and the clearing after a gate drop. A projected detection appears one clock after the slot MARK_GAP valid bytes past the 1Fh, not counting idle cycles in between. The bench drives inputs on the falling edge. Its behavioural model advances on the rising edge, and every output is compared a quarter period after that edge, so each comparison sees the register state produced by exactly one edge.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2
  } dsd_state_e;
endpackage

// File: rtl/dsd_mark_cmp.sv
module dsd_mark_cmp #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] MARK_A = 8'h1F,
  parameter logic [DW-1:0] MARK_B = 8'h69
) (
  input  logic [DW-1:0] byte_i,
  output logic          hit_a_o,
  output logic          hit_b_o
);
  localparam int unsigned NM = 2;
  logic [DW-1:0] marks [NM];
  logic [NM-1:0] hits;

  assign marks[0] = MARK_A;
  assign marks[1] = MARK_B;

  for (genvar m = 0; m < NM; m++) begin : g_cmp
    assign hits[m] = (byte_i == marks[m]);
  end

  assign hit_a_o = hits[0];
  assign hit_b_o = hits[1];
endmodule

// File: rtl/dsd_ctrl.sv
module dsd_ctrl
  import dsd_pkg::*;
#(
  parameter int unsigned MARK_GAP = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_gate_i,
  input  logic byte_vld_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic fire_o,
  output logic locked_o
);
  localparam int unsigned CW = (MARK_GAP > 1) ? $clog2(MARK_GAP) : 1;
  localparam logic [CW-1:0] ARM_LOAD = CW'(MARK_GAP - 1);

  dsd_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          slot;

  assign slot = rd_gate_i & byte_vld_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fire_o  = 1'b0;
    unique case (state_q)
      ST_HUNT: if (slot) begin
        if (hit_b_i) begin
          fire_o  = 1'b1;
          state_d = ST_LOCKED;
        end else if (hit_a_i) begin
          state_d = ST_ARMED;
          cnt_d   = ARM_LOAD;
        end
      end
      ST_ARMED: if (slot) begin
        // projected slot: content ignored
        if (hit_b_i || cnt_q == '0) begin
          fire_o  = 1'b1;
          state_d = ST_LOCKED;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ;
    endcase
    if (!rd_gate_i) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign locked_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/dsd_out.sv
module dsd_out #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] MARK_B = 8'h69
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_gate_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic          fire_i,
  input  logic          locked_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          sync_det_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sync_det_o <= 1'b0;
    end else if (!rd_gate_i) begin
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      sync_det_o <= 1'b0;
    end else begin
      byte_vld_o <= byte_vld_i;
      sync_det_o <= fire_i;
      if (byte_vld_i) begin
        if (fire_i)        byte_o <= MARK_B;
        else if (locked_i) byte_o <= byte_i;
        else               byte_o <= '0;
      end
    end
  end
endmodule

// File: rtl/dual_sync_det.sv
module dual_sync_det #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] MARK_A = 8'h1F,
  parameter logic [DW-1:0] MARK_B = 8'h69,
  parameter int unsigned MARK_GAP = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_gate_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  output logic          byte_vld_o,
  output logic [DW-1:0] byte_o,
  output logic          sync_det_o,
  output logic          sync_found_o
);
  logic hit_a, hit_b, fire, locked;

  dsd_mark_cmp #(.DW(DW), .MARK_A(MARK_A), .MARK_B(MARK_B)) u_cmp (
    .byte_i (byte_i),
    .hit_a_o(hit_a),
    .hit_b_o(hit_b)
  );

  dsd_ctrl #(.MARK_GAP(MARK_GAP)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_gate_i (rd_gate_i),
    .byte_vld_i(byte_vld_i),
    .hit_a_i   (hit_a),
    .hit_b_i   (hit_b),
    .fire_o    (fire),
    .locked_o  (locked)
  );

  dsd_out #(.DW(DW), .MARK_B(MARK_B)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_gate_i (rd_gate_i),
    .byte_vld_i(byte_vld_i),
    .byte_i    (byte_i),
    .fire_i    (fire),
    .locked_i  (locked),
    .byte_vld_o(byte_vld_o),
    .byte_o    (byte_o),
    .sync_det_o(sync_det_o)
  );

  assign sync_found_o = locked;
endmodule

// File: rtl/dsd_chk.sv
module dsd_chk #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] MARK_B = 8'h69
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_gate_i,
  input logic          byte_vld_i,
  input logic [DW-1:0] byte_i,
  input logic          byte_vld_o,
  input logic [DW-1:0] byte_o,
  input logic          sync_det_o,
  input logic          sync_found_o
);
  // R1
  gate_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_gate_i |=> (byte_o == '0 && !byte_vld_o && !sync_det_o && !sync_found_o));

  // R3
  direct_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gate_i && byte_vld_i && byte_i == MARK_B && !sync_found_o)
      |=> (sync_det_o && sync_found_o && byte_o == MARK_B));

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gate_i && !byte_vld_i) |=> (!byte_vld_o && !sync_det_o && $stable(byte_o)));

  // R6
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gate_i && byte_vld_i && sync_found_o) |=> (byte_vld_o && byte_o == $past(byte_i)));

  // R8
  det_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_det_o |=> !sync_det_o);

  // R8
  det_marker_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_det_o |-> (sync_found_o && byte_o == MARK_B && byte_vld_o));

  // R8
  found_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_found_o && rd_gate_i) |=> sync_found_o);
endmodule

bind dual_sync_det dsd_chk #(.DW(DW), .MARK_B(MARK_B)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_gate_i   (rd_gate_i),
  .byte_vld_i  (byte_vld_i),
  .byte_i      (byte_i),
  .byte_vld_o  (byte_vld_o),
  .byte_o      (byte_o),
  .sync_det_o  (sync_det_o),
  .sync_found_o(sync_found_o)
);

// File: tb/tb_dual_sync_det.sv
`timescale 1ns/1ps
module tb_dual_sync_det;
  localparam int GAP = 1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_gate_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       byte_vld_o, sync_det_o, sync_found_o;
  logic [7:0] byte_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference model state
  int         m_arm = 0;
  bit         m_found = 0;
  logic [7:0] e_byte = 8'h00;
  bit         e_vld = 0, e_det = 0, e_found = 0;
  string      e_tag = "R1";

  always #10 clk_i = ~clk_i;

  dual_sync_det #(.MARK_GAP(GAP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_gate_i(rd_gate_i),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o),
    .sync_det_o(sync_det_o), .sync_found_o(sync_found_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || !rd_gate_i) begin
      m_arm = 0; m_found = 0;
      e_byte = 8'h00; e_vld = 0; e_det = 0;
      e_tag = !rst_ni ? "R1" : "R7";
    end else if (!byte_vld_i) begin
      e_vld = 0; e_det = 0; e_tag = "R5";
    end else begin
      e_vld = 1;
      if (m_found) begin
        e_byte = byte_i; e_det = 0; e_tag = "R6";
      end else if (byte_i == 8'h69) begin
        m_found = 1; m_arm = 0; e_byte = 8'h69; e_det = 1; e_tag = "R3";
      end else if (m_arm == 1) begin
        m_found = 1; m_arm = 0; e_byte = 8'h69; e_det = 1; e_tag = "R4";
      end else begin
        e_byte = 8'h00; e_det = 0; e_tag = "R2";
        if (m_arm > 1) m_arm--;
        else if (byte_i == 8'h1F) m_arm = GAP;
      end
    end
    e_found = m_found;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    #5;
    if (!done) begin
      chk(byte_o == e_byte, e_tag, "byte_o", byte_o, e_byte);
      chk(byte_vld_o == e_vld, e_tag, "byte_vld_o", byte_vld_o, e_vld);
      chk(sync_det_o == e_det, (e_det || sync_det_o) ? "R8" : e_tag, "sync_det_o", sync_det_o, e_det);
      chk(sync_found_o == e_found, e_found ? "R8" : e_tag, "sync_found_o", sync_found_o, e_found);
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk_i); byte_vld_i = 1'b1; byte_i = b;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk_i); byte_vld_i = 1'b0; byte_i = 8'hA5; end
  endtask

  task automatic gate(input bit g);
    @(negedge clk_i); byte_vld_i = 1'b0; rd_gate_i = g;
  endtask

  initial begin
    #200000000;
    n_err++;
    $display("FAIL watchdog actual=hung expected=finish");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);
    // R2, R3, R6, R8: direct hit on second mark, then pass-through
    gate(1);
    put(8'h00); put(8'h12); put(8'h34); put(8'h69);
    put(8'hAA); put(8'hBB); put(8'h1F); put(8'h69); put(8'h5C);
    idle(2);
    // R7: gate drop clears lock
    gate(0); idle(2);
    // R4: first mark only, projected slot content ignored
    gate(1);
    put(8'h55); put(8'h1F); put(8'hE7); put(8'hC3); put(8'h1F);
    gate(0);
    // R5: idle cycles between 1Fh and the projected slot
    gate(1);
    put(8'h00); put(8'h1F); idle(3); put(8'h00); idle(1); put(8'h77);
    gate(0);
    // R4: both marks present, one detection only (R8)
    gate(1);
    put(8'h00); put(8'h1F); put(8'h69); put(8'h69); put(8'h1F);
    gate(0);
    // R7: armed wait cancelled by gate drop
    gate(1);
    put(8'h11); put(8'h1F);
    gate(0); idle(1);
    gate(1);
    put(8'h00); put(8'h22); put(8'h33);
    // R4: back-to-back 1Fh does not restart wait
    put(8'h1F); put(8'h1F); put(8'h44);
    gate(0);
    // R3: only the second mark is written
    gate(1);
    for (int i = 0; i < 5; i++) put(8'h00);
    put(8'h69); put(8'h9E); put(8'h00);
    idle(3);
    gate(0); idle(2);
    @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule